// File: doc/BRIEF.md
# Octant Reconstruction Output Stage

This block sits at the end of a sine/cosine synthesizer pipeline. The rotation core works only on the first eighth of the circle, so it returns a cosine and a sine for a reduced angle θ between 0 and π/4. This stage rebuilds the cosine and sine of the full-circle phase from those two values. It uses the three most significant phase bits, which select the octant.

The octant bits are taken from the phase at the time the phase enters the pipeline. A register chain as deep as the core (`DEPTH`) carries them forward. When the core result for that phase arrives, the delayed bits are decoded into three controls. Two controls negate the core cosine and the core sine independently. The third control exchanges the two. The results are registered. Negating the most negative code gives the most positive code, so a full-scale input cannot wrap.

Top module: `octant_rebuild`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0 at that edge. Reset also clears every stage of the octant delay chain to octant 000.
- R2: The octant applied to a core sample is the value of `oct_in` sampled `DEPTH` clock edges before the edge that captures that sample. The octant present at the capture edge itself has no effect.
- R3: For octants 001, 010, 101 and 110, `cos_out` is built from the core sine and `sin_out` from the core cosine. For octants 000, 011, 100 and 111, each output is built from its own input.
- R4: `cos_out` holds the negated source value for octants 010, 011, 100 and 101, and the source value unchanged for the other octants.
- R5: `sin_out` holds the negated source value for octants 100, 101, 110 and 111, and the source value unchanged for octants 000 to 011.
- R6: Negating −2^(W−1) (−32768 at W=16) gives 2^(W−1)−1 (32767). The value −2^(W−1) passes through unchanged when no negation applies.
- R7: The outputs are registered. They change at the first clock edge after the core values are applied and hold until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oct_in | input | 3 | Octant bits (top three phase bits) taken at pipeline entry |
| cos_in | input | W (16) | First-octant cosine from the core, signed |
| sin_in | input | W (16) | First-octant sine from the core, signed |
| cos_out | output | W (16) | Full-circle cosine, signed, registered |
| sin_out | output | W (16) | Full-circle sine, signed, registered |

## Verification
The hardest condition to create from the ports is a mismatch between the octant that reaches the decoder and the octant on the input at the same moment. A design that skips the delay, or uses one stage too many or too few, still gives correct results whenever the octant is held steady. To expose this, each vector applies its octant for exactly one edge and then drives the bitwise complement for the rest of the `DEPTH` window. Only a chain with the exact depth then selects the intended octant. A reset in the middle of a run, followed at once by a new octant, also shows whether reset really empties the chain.

// File: rtl/octr_pkg.sv
package octr_pkg;
  // Control word decoded from one octant code
  typedef struct packed {
    logic xinv;  // negate core cosine
    logic yinv;  // negate core sine
    logic swap;  // exchange after negation
  } octr_ctl_t;

  localparam int OCT_BITS = 3;
endpackage

// File: rtl/octr_delay.sv
module octr_delay #(
  parameter int DEPTH = 9,
  parameter int BITS  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_thru
      assign q = d;
    end else begin : g_chain
      logic [BITS-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/octr_decode.sv
module octr_decode
  import octr_pkg::*;
(
  input  logic [OCT_BITS-1:0] oct,
  output octr_ctl_t           ctl
);
  always_comb begin
    unique case (oct)
      3'b000:  ctl = '{xinv: 1'b0, yinv: 1'b0, swap: 1'b0};
      3'b001:  ctl = '{xinv: 1'b0, yinv: 1'b0, swap: 1'b1};
      3'b010:  ctl = '{xinv: 1'b0, yinv: 1'b1, swap: 1'b1};
      3'b011:  ctl = '{xinv: 1'b1, yinv: 1'b0, swap: 1'b0};
      3'b100:  ctl = '{xinv: 1'b1, yinv: 1'b1, swap: 1'b0};
      3'b101:  ctl = '{xinv: 1'b1, yinv: 1'b1, swap: 1'b1};
      3'b110:  ctl = '{xinv: 1'b1, yinv: 1'b0, swap: 1'b1};
      default: ctl = '{xinv: 1'b0, yinv: 1'b1, swap: 1'b0};
    endcase
  end
endmodule

// File: rtl/octr_negsat.sv
module octr_negsat #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] a,
  input  logic                neg,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!neg)          y = a;
    else if (a == MINV) y = MAXV;
    else               y = -a;
  end
endmodule

// File: rtl/octant_rebuild.sv
module octant_rebuild
  import octr_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          oct_in,
  input  logic signed [W-1:0] cos_in,
  input  logic signed [W-1:0] sin_in,
  output logic signed [W-1:0] cos_out,
  output logic signed [W-1:0] sin_out
);
  logic [OCT_BITS-1:0] oct_al;
  octr_ctl_t           ctl;
  logic signed [W-1:0] x_n, y_n;

  octr_delay #(.DEPTH(DEPTH), .BITS(OCT_BITS)) u_dly (
    .clk(clk), .rst(rst), .d(oct_in), .q(oct_al)
  );

  octr_decode u_dec (.oct(oct_al), .ctl(ctl));

  octr_negsat #(.W(W)) u_negx (.a(cos_in), .neg(ctl.xinv), .y(x_n));
  octr_negsat #(.W(W)) u_negy (.a(sin_in), .neg(ctl.yinv), .y(y_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_out <= '0;
      sin_out <= '0;
    end else if (ctl.swap) begin
      cos_out <= y_n;
      sin_out <= x_n;
    end else begin
      cos_out <= x_n;
      sin_out <= y_n;
    end
  end
endmodule

// File: rtl/octr_chk.sv
module octr_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 9
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          oct_in,
  input logic signed [W-1:0] cos_in,
  input logic signed [W-1:0] sin_in,
  input logic signed [W-1:0] cos_out,
  input logic signed [W-1:0] sin_out
);
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic [2:0] c_oct;

  generate
    if (DEPTH == 0) begin : g_thru
      assign c_oct = oct_in;
    end else begin : g_chain
      logic [2:0] sh [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) sh[i] <= '0;
        end else begin
          sh[0] <= oct_in;
          for (int i = 1; i < DEPTH; i++) sh[i] <= sh[i-1];
        end
      end
      assign c_oct = sh[DEPTH-1];
    end
  endgenerate

  function automatic logic signed [W-1:0] mag(input logic signed [W-1:0] v);
    if (v == MINV)   return MAXV;
    else if (v < 0)  return -v;
    else             return v;
  endfunction

  function automatic logic signed [W-1:0] sneg(input logic signed [W-1:0] v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  logic swap_oct;
  assign swap_oct = c_oct[0] ^ c_oct[1];

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (cos_out == '0 && sin_out == '0)); // R1
  AST_SWAP_SRC: assert property (@(posedge clk) disable iff (rst) swap_oct |=> (mag(cos_out) == mag($past(sin_in)) && mag(sin_out) == mag($past(cos_in)))); // R3
  AST_OCT0_PASS: assert property (@(posedge clk) disable iff (rst) (c_oct == 3'b000) |=> (cos_out == $past(cos_in) && sin_out == $past(sin_in))); // R2
  AST_COS_NEG: assert property (@(posedge clk) disable iff (rst) (c_oct == 3'b011) |=> (cos_out == sneg($past(cos_in)) && sin_out == $past(sin_in))); // R4
  AST_SIN_NEG: assert property (@(posedge clk) disable iff (rst) (c_oct == 3'b111) |=> (sin_out == sneg($past(sin_in)) && cos_out == $past(cos_in))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (c_oct == 3'b100 && cos_in == MINV) |=> (cos_out == MAXV)); // R6
endmodule

bind octant_rebuild octr_chk #(.W(W), .DEPTH(DEPTH)) u_octr_chk (
  .clk(clk), .rst(rst), .oct_in(oct_in), .cos_in(cos_in), .sin_in(sin_in),
  .cos_out(cos_out), .sin_out(sin_out)
);

// File: tb/test_octant_rebuild.sv
module test_octant_rebuild;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int DEPTH = 9;
  localparam int NV = 8;

  // octant, core cos, core sin, expected cos, expected sin
  localparam logic [2:0] V_OCT [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic signed [W-1:0] V_C [NV] = '{16'sd30000, 16'sd29000, 16'sd28000, 16'sd27000,
                                              16'sd26000, 16'sd25000, 16'sd24000, 16'sd23000};
  localparam logic signed [W-1:0] V_S [NV] = '{16'sd1000, 16'sd2000, 16'sd3000, 16'sd4000,
                                              16'sd5000, 16'sd6000, 16'sd7000, 16'sd8000};
  localparam logic signed [W-1:0] E_C [NV] = '{16'sd30000, 16'sd2000, -16'sd3000, -16'sd27000,
                                              -16'sd26000, -16'sd6000, 16'sd7000, 16'sd23000};
  localparam logic signed [W-1:0] E_S [NV] = '{16'sd1000, 16'sd29000, 16'sd28000, 16'sd4000,
                                              -16'sd5000, -16'sd25000, -16'sd24000, -16'sd8000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] oct_in = '0;
  logic signed [W-1:0] cos_in = '0, sin_in = '0;
  logic signed [W-1:0] cos_out, sin_out;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  octant_rebuild #(.W(W), .DEPTH(DEPTH)) i_octant_rebuild (
    .clk(clk), .rst(rst), .oct_in(oct_in), .cos_in(cos_in), .sin_in(sin_in),
    .cos_out(cos_out), .sin_out(sin_out)
  );

  task automatic chk(input string req, input logic signed [W-1:0] ec, input logic signed [W-1:0] es);
    n_chk++;
    if (cos_out !== ec || sin_out !== es) begin
      n_err++;
      $display("FAIL %s: got cos=%0d sin=%0d, expected cos=%0d sin=%0d", req, cos_out, sin_out, ec, es);
    end
  endtask

  // Octant held for one edge, then its complement for the rest of the window
  task automatic run_vec(input logic [2:0] o, input logic signed [W-1:0] c, input logic signed [W-1:0] s);
    oct_in = o;
    @(negedge clk);
    oct_in = ~o;
    repeat (DEPTH-1) @(negedge clk);
    cos_in = c;
    sin_in = s;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_err++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    cos_in = 16'sd1234;
    sin_in = 16'sd4321;
    repeat (3) @(negedge clk);
    chk("R1 reset state", 16'sd0, 16'sd0);
    rst = 1'b0;

    // Table walk: R2 alignment, R3 swap, R4 cos sign, R5 sin sign
    for (int i = 0; i < NV; i++) begin
      run_vec(V_OCT[i], V_C[i], V_S[i]);
      chk($sformatf("R2 R3 R4 R5 octant %0d", V_OCT[i]), E_C[i], E_S[i]);
    end

    // R6: saturation on negation, passthrough otherwise
    run_vec(3'b011, -16'sd32768, 16'sd100);
    chk("R6 cos negate of min", 16'sd32767, 16'sd100);
    run_vec(3'b100, 16'sd50, -16'sd32768);
    chk("R6 sin negate of min", -16'sd50, 16'sd32767);
    run_vec(3'b000, -16'sd32768, -16'sd32768);
    chk("R6 min passes unnegated", -16'sd32768, -16'sd32768);
    run_vec(3'b101, -16'sd32768, 16'sd0);
    chk("R6 swapped min negated", 16'sd0, 16'sd32767);

    // R7: registered output, changes only at the next edge
    oct_in = 3'b000;
    repeat (DEPTH+1) @(negedge clk);
    cos_in = 16'sd111;
    sin_in = 16'sd222;
    @(negedge clk);
    chk("R7 first value", 16'sd111, 16'sd222);
    cos_in = 16'sd333;
    sin_in = 16'sd444;
    #1;
    chk("R7 hold before edge", 16'sd111, 16'sd222);
    @(negedge clk);
    chk("R7 update after edge", 16'sd333, 16'sd444);

    // R1: mid-run reset clears outputs and the octant chain
    oct_in = 3'b111;
    repeat (DEPTH+1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-run", 16'sd0, 16'sd0);
    rst = 1'b0;
    oct_in = 3'b111;
    cos_in = 16'sd500;
    sin_in = 16'sd600;
    @(negedge clk);
    chk("R1 chain cleared to octant 000", 16'sd500, 16'sd600);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule